// File: doc/BRIEF.md
# Endian-Aware External Bus Sizing Unit

This unit connects a 32-bit internal master to one external memory port. The port's data path is either 8 or 16 bits wide. The master hands over one request: an area index, a byte address, an access size, a direction and up to 32 bits of write data. The unit breaks the request into one, two or four external cycles. On each cycle it places every byte on the data lane that its address selects and raises a strobe for each lane it uses. On reads it gathers the returned lanes into a result that is aligned to bit 0.

Eight areas each carry two configuration bits. One selects byte order and the other selects the bus width. Both bits are captured when a request is accepted, so a change made while a split transfer is running affects only later requests. A request whose address does not suit its size is rejected with an error and never reaches the external port.

Top module: `bus_sizer`

## Requirements
- R1: After reset, `req_ready` is 1, and `ext_valid`, `rsp_done` and `rsp_err` are 0.
- R2: An accepted aligned request produces the following number of external cycles:
  - 16-bit area: 1 for a byte or a word, 2 for a longword.
  - 8-bit area: 1 for a byte, 2 for a word, 4 for a longword.
  - Each cycle holds `ext_valid` and its address until `ext_ack`.
  - Cycle addresses start at the request address and step by the bus width in bytes (1 or 2).
- R3: Big-endian 16-bit areas (`cfg_big` bit = 1, `cfg_wide` bit = 1). An even address maps to the upper lane (`ext_wdata[15:8]`, strobe bit 1) and an odd address maps to the lower lane (strobe bit 0). A word sends data bits 15..8 on the upper lane and 7..0 on the lower lane. A longword sends bits 31..16 in its first cycle and bits 15..0 in its second cycle, with the higher byte on the upper lane.
- R4: Little-endian 16-bit areas. An even address maps to the lower lane and an odd address maps to the upper lane. A word sends bits 7..0 on the lower lane. A longword sends bits 15..0 first and bits 31..16 second.
- R5: 8-bit areas use only the lower lane and strobe bit 0. Longword and word bytes go out from most to least significant in big-endian mode, and from least to most significant in little-endian mode.
- R6: A lane whose strobe is 0 is driven with 0 on a write. On a read, `ext_wdata` is 0. `ext_write` follows the request's direction.
- R7: A read returns the gathered bytes in `rsp_rdata`, aligned to bit 0. Bits above the access size are 0. Data on lanes whose strobe is 0 is ignored.
- R8: A word at an odd address, a longword at an address not divisible by 4, or the reserved size code 3 starts no external cycle. The cycle after acceptance, such a request gives one cycle with both `rsp_done` and `rsp_err` high.
- R9: `req_ready` is 0 from acceptance until the done cycle ends. `rsp_done` is a single-cycle pulse in the cycle after the last `ext_ack`. `rsp_rdata` is valid only during that pulse.
- R10: The area's endian and width bits are sampled when the request is accepted. Changing them while the request runs has no effect on its remaining cycles.

Size codes: 0 byte, 1 word, 2 longword. Strobe bit 1 is the upper lane; strobe bit 0 is the lower lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big | input | 8 | Per-area byte order, 1 = big endian |
| cfg_wide | input | 8 | Per-area bus width, 1 = 16-bit, 0 = 8-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_area | input | 3 | Area index |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, aligned to bit 0 |
| rsp_done | output | 1 | Request finished (pulse) |
| rsp_err | output | 1 | Request rejected, valid with rsp_done |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| ext_valid | output | 1 | External cycle active |
| ext_addr | output | AW | External cycle byte address |
| ext_write | output | 1 | External cycle direction |
| ext_strb | output | 2 | Lane strobes |
| ext_wdata | output | 16 | External write lanes |
| ext_rdata | input | 16 | External read lanes |
| ext_ack | input | 1 | External cycle complete |

## Verification
The hardest situation to reach is a configuration change in the middle of a split transfer. The master cannot see the beat boundaries, so the stimulus has to act in the narrow window between two beats. The bench takes over the external responder for this case. After it acknowledges the first of the four byte cycles of an 8-bit big-endian longword, it flips that area's endian and width bits. It then checks that the next three cycles still use the lower lane in most-significant-first order. Every mapping vector is also run with the other areas set to the opposite configuration, so a wrong area lookup shows up as a wrong lane.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LANES   = 2;
    localparam int unsigned LANE_W  = 8;
endpackage

// File: rtl/bsz_lane_map.sv
module bsz_lane_map
    import bsz_pkg::*;
#(
    parameter int unsigned NLANE = LANES
) (
    input  logic                    big,
    input  logic                    wide,
    input  logic                    write,
    input  logic [1:0]              size,
    input  logic [1:0]              beat_off,
    input  logic                    base_par,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NLANE*LANE_W-1:0] rlanes,
    input  logic [DATA_W-1:0]       acc_in,
    output logic [NLANE-1:0]        strb,
    output logic [NLANE*LANE_W-1:0] wlanes,
    output logic [DATA_W-1:0]       acc_out
);
    logic [2:0] nbytes;
    assign nbytes = 3'd1 << size;

    logic [1:0] idx [NLANE];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic       lane_par;
        logic [2:0] k_d;
        logic [2:0] rev_d;
        logic       hit_d;

        always_comb begin
            lane_par = 1'b0;
            hit_d    = 1'b0;
            k_d      = 3'd0;
            if (wide) begin
                lane_par = big ? (l == 0) : (l == 1);
                k_d      = {1'b0, beat_off} + {2'b00, lane_par} - {2'b00, base_par};
                hit_d    = (lane_par >= base_par) && (k_d < nbytes);
            end else begin
                k_d   = {1'b0, beat_off};
                hit_d = (l == 0);
            end
            rev_d  = nbytes - 3'd1 - k_d;
            idx[l] = big ? rev_d[1:0] : k_d[1:0];
        end

        assign strb[l] = hit_d;
        assign wlanes[l*LANE_W +: LANE_W] =
            (hit_d && write) ? wdata[{idx[l], 3'b000} +: LANE_W] : '0;
    end

    always_comb begin
        acc_out = acc_in;
        for (int l = 0; l < NLANE; l++) begin
            if (strb[l]) acc_out[{idx[l], 3'b000} +: LANE_W] = rlanes[l*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
    import bsz_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned NAREA  = 8,
    localparam int unsigned AREA_W = $clog2(NAREA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NAREA-1:0]  cfg_big,
    input  logic [NAREA-1:0]  cfg_wide,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AREA_W-1:0] req_area,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] acc_merge,
    output logic              ext_valid,
    output logic [AW-1:0]     ext_addr,
    output logic              cur_write,
    output logic              cur_big,
    output logic              cur_wide,
    output logic [1:0]        cur_size,
    output logic [1:0]        beat_off,
    output logic              base_par,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] acc_q_o,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        state_e            state;
        logic [AW-1:0]     addr;
        logic              big;
        logic              wide;
        logic [1:0]        size;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        beat;
        logic [1:0]        last;
        logic [DATA_W-1:0] acc;
        logic              err;
    } seq_t;

    seq_t r_q, r_d;

    logic misalign;
    logic sel_wide;
    always_comb begin
        sel_wide = cfg_wide[req_area];
        unique case (size_e'(req_size))
            SZ_BYTE: misalign = 1'b0;
            SZ_WORD: misalign = req_addr[0];
            SZ_LONG: misalign = |req_addr[1:0];
            default: misalign = 1'b1;
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.big   = cfg_big[req_area];
                    r_d.wide  = sel_wide;
                    r_d.size  = req_size;
                    r_d.write = req_write;
                    r_d.wdata = req_wdata;
                    r_d.beat  = 2'd0;
                    r_d.acc   = '0;
                    r_d.err   = misalign;
                    if (sel_wide) r_d.last = (req_size == SZ_LONG) ? 2'd1 : 2'd0;
                    else          r_d.last = (req_size == SZ_LONG) ? 2'd3 :
                                             (req_size == SZ_WORD) ? 2'd1 : 2'd0;
                    r_d.state = misalign ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (ext_ack) begin
                    r_d.acc = acc_merge;
                    if (r_q.beat == r_q.last) r_d.state = ST_DONE;
                    else                      r_d.beat  = r_q.beat + 2'd1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign ext_valid = (r_q.state == ST_RUN);
    assign beat_off  = r_q.wide ? {r_q.beat[0], 1'b0} : r_q.beat;
    assign ext_addr  = r_q.addr + AW'(beat_off);
    assign base_par  = r_q.addr[0];
    assign cur_write = r_q.write;
    assign cur_big   = r_q.big;
    assign cur_wide  = r_q.wide;
    assign cur_size  = r_q.size;
    assign cur_wdata = r_q.wdata;
    assign acc_q_o   = r_q.acc;
    assign rsp_done  = (r_q.state == ST_DONE);
    assign rsp_err   = rsp_done && r_q.err;
    assign rsp_rdata = (rsp_done && !r_q.write && !r_q.err) ? r_q.acc : '0;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> !req_ready);
    p_cycle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && !ext_ack |=> ext_valid && $stable(ext_addr));
    p_err_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !ext_valid && !$past(ext_valid));
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
    import bsz_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned NAREA  = 8,
    localparam int unsigned AREA_W = $clog2(NAREA),
    localparam int unsigned EXT_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NAREA-1:0]  cfg_big,
    input  logic [NAREA-1:0]  cfg_wide,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AREA_W-1:0] req_area,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ext_valid,
    output logic [AW-1:0]     ext_addr,
    output logic              ext_write,
    output logic [LANES-1:0]  ext_strb,
    output logic [EXT_W-1:0]  ext_wdata,
    input  logic [EXT_W-1:0]  ext_rdata,
    input  logic              ext_ack
);
    logic              cur_write, cur_big, cur_wide, base_par;
    logic [1:0]        cur_size, beat_off;
    logic [DATA_W-1:0] cur_wdata, acc_q, acc_merge;
    logic [LANES-1:0]  strb_raw;
    logic [EXT_W-1:0]  wl_raw;

    bsz_seq #(.AW(AW), .NAREA(NAREA)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .ext_ack(ext_ack), .acc_merge(acc_merge),
        .ext_valid(ext_valid), .ext_addr(ext_addr), .cur_write(cur_write),
        .cur_big(cur_big), .cur_wide(cur_wide), .cur_size(cur_size),
        .beat_off(beat_off), .base_par(base_par), .cur_wdata(cur_wdata),
        .acc_q_o(acc_q), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    bsz_lane_map #(.NLANE(LANES)) u_map (
        .big(cur_big), .wide(cur_wide), .write(cur_write), .size(cur_size),
        .beat_off(beat_off), .base_par(base_par), .wdata(cur_wdata),
        .rlanes(ext_rdata), .acc_in(acc_q), .strb(strb_raw),
        .wlanes(wl_raw), .acc_out(acc_merge)
    );

    assign ext_write = ext_valid && cur_write;
    assign ext_strb  = ext_valid ? strb_raw : '0;
    assign ext_wdata = ext_valid ? wl_raw : '0;

    p_narrow_low_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && !cur_wide |-> ext_strb == 2'b01);
    p_strobe_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> ext_strb != '0);
    p_idle_lanes_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && !ext_strb[1] |-> ext_wdata[15:8] == 8'h00);
endmodule

// File: tb/sim_bus_sizer.sv
`timescale 1ns/1ps
module sim_bus_sizer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_big, cfg_wide;
    logic        req_valid, req_ready, req_write;
    logic [2:0]  req_area;
    logic [31:0] req_addr, req_wdata, rsp_rdata, ext_addr;
    logic [1:0]  req_size, ext_strb;
    logic        rsp_done, rsp_err, ext_valid, ext_write, ext_ack;
    logic [15:0] ext_wdata, ext_rdata;

    always #2.5 clk = ~clk;

    bus_sizer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ext_valid(ext_valid), .ext_addr(ext_addr),
        .ext_write(ext_write), .ext_strb(ext_strb), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    typedef struct packed {
        logic [2:0]        area;
        logic              big;
        logic              wide;
        logic [1:0]        size;
        logic [7:0]        addr;
        logic [2:0]        nb;
        logic [0:3][17:0]  beats;
    } vec_t;

    localparam logic [31:0] W = 32'hA1B2C3D4;
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b1, 1'b1, 2'd0, 8'h00, 3'd1, {{2'b10,16'hD400}, 18'h0, 18'h0, 18'h0}},
        '{3'd1, 1'b1, 1'b1, 2'd0, 8'h01, 3'd1, {{2'b01,16'h00D4}, 18'h0, 18'h0, 18'h0}},
        '{3'd2, 1'b0, 1'b1, 2'd0, 8'h04, 3'd1, {{2'b01,16'h00D4}, 18'h0, 18'h0, 18'h0}},
        '{3'd3, 1'b0, 1'b1, 2'd0, 8'h03, 3'd1, {{2'b10,16'hD400}, 18'h0, 18'h0, 18'h0}},
        '{3'd4, 1'b1, 1'b1, 2'd1, 8'h02, 3'd1, {{2'b11,16'hC3D4}, 18'h0, 18'h0, 18'h0}},
        '{3'd5, 1'b0, 1'b1, 2'd1, 8'h00, 3'd1, {{2'b11,16'hC3D4}, 18'h0, 18'h0, 18'h0}},
        '{3'd6, 1'b1, 1'b1, 2'd2, 8'h00, 3'd2, {{2'b11,16'hA1B2}, {2'b11,16'hC3D4}, 18'h0, 18'h0}},
        '{3'd7, 1'b0, 1'b1, 2'd2, 8'h04, 3'd2, {{2'b11,16'hC3D4}, {2'b11,16'hA1B2}, 18'h0, 18'h0}},
        '{3'd0, 1'b1, 1'b0, 2'd2, 8'h08, 3'd4, {{2'b01,16'h00A1}, {2'b01,16'h00B2}, {2'b01,16'h00C3}, {2'b01,16'h00D4}}},
        '{3'd1, 1'b0, 1'b0, 2'd2, 8'h00, 3'd4, {{2'b01,16'h00D4}, {2'b01,16'h00C3}, {2'b01,16'h00B2}, {2'b01,16'h00A1}}},
        '{3'd2, 1'b1, 1'b0, 2'd1, 8'h06, 3'd2, {{2'b01,16'h00C3}, {2'b01,16'h00D4}, 18'h0, 18'h0}},
        '{3'd3, 1'b0, 1'b0, 2'd1, 8'h02, 3'd2, {{2'b01,16'h00D4}, {2'b01,16'h00C3}, 18'h0, 18'h0}},
        '{3'd4, 1'b1, 1'b0, 2'd0, 8'h05, 3'd1, {{2'b01,16'h00D4}, 18'h0, 18'h0, 18'h0}},
        '{3'd5, 1'b0, 1'b0, 2'd0, 8'h07, 3'd1, {{2'b01,16'h00D4}, 18'h0, 18'h0, 18'h0}}
    };

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] area, input logic [1:0] size, input logic [31:0] addr, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_area = area; req_size = size;
        req_addr = addr; req_write = wr; req_wdata = W;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input logic wr, input logic flip);
        logic [31:0] exp_r;
        cfg_big  = v.big  ? (8'h01 << v.area) : ~(8'h01 << v.area);
        cfg_wide = v.wide ? (8'h01 << v.area) : ~(8'h01 << v.area);
        issue(v.area, v.size, {24'h0, v.addr}, wr);
        for (int i = 0; i < int'(v.nb); i++) begin
            logic [1:0]  s;
            logic [15:0] d, m;
            s = v.beats[i][17:16];
            d = v.beats[i][15:0];
            m = {{8{s[1]}}, {8{s[0]}}};
            @(negedge clk);
            chk(ext_valid === 1'b1, "R2 cycle present", {31'h0, ext_valid}, 32'h1);
            chk(ext_addr === {24'h0, v.addr} + (v.wide ? 32'(2*i) : 32'(i)), "R2 cycle address", ext_addr,
                {24'h0, v.addr} + (v.wide ? 32'(2*i) : 32'(i)));
            chk(ext_strb === s, v.wide ? (v.big ? "R3 strobes" : "R4 strobes") : "R5 strobes", {30'h0, ext_strb}, {30'h0, s});
            chk(req_ready === 1'b0, "R9 ready low while busy", {31'h0, req_ready}, 32'h0);
            chk(ext_write === wr, "R6 direction", {31'h0, ext_write}, {31'h0, wr});
            if (wr) chk(ext_wdata === d, v.wide ? (v.big ? "R3 lanes" : "R4 lanes") : "R5 lanes", {16'h0, ext_wdata}, {16'h0, d});
            else    chk(ext_wdata === 16'h0, "R6 read lanes zero", {16'h0, ext_wdata}, 32'h0);
            ext_rdata = (d & m) | (16'h5A5A & ~m);
            ext_ack = 1'b1;
            @(posedge clk); #1;
            ext_ack = 1'b0;
            if (flip && i == 0) begin
                cfg_big  = ~cfg_big;   // R10: flip mid-transfer
                cfg_wide = ~cfg_wide;
            end
        end
        exp_r = (v.size == 2'd0) ? (W & 32'hFF) : (v.size == 2'd1) ? (W & 32'hFFFF) : W;
        @(negedge clk);
        chk(rsp_done === 1'b1 && rsp_err === 1'b0, "R9 done pulse", {30'h0, rsp_done, rsp_err}, 32'h2);
        chk(ext_valid === 1'b0, "R2 no extra cycle", {31'h0, ext_valid}, 32'h0);
        if (!wr) chk(rsp_rdata === exp_r, "R7 read packing", rsp_rdata, exp_r);
        @(negedge clk);
        chk(rsp_done === 1'b0 && req_ready === 1'b1, "R9 single pulse", {30'h0, rsp_done, req_ready}, 32'h1);
    endtask

    task automatic bad_req(input logic wide, input logic [1:0] size, input logic [31:0] addr);
        cfg_big = 8'hFF; cfg_wide = wide ? 8'hFF : 8'h00;
        issue(3'd6, size, addr, 1'b0);
        @(negedge clk);
        chk(rsp_done === 1'b1 && rsp_err === 1'b1, "R8 error response", {30'h0, rsp_done, rsp_err}, 32'h3);
        chk(ext_valid === 1'b0, "R8 no external cycle", {31'h0, ext_valid}, 32'h0);
        @(negedge clk);
        chk(rsp_done === 1'b0 && req_ready === 1'b1 && ext_valid === 1'b0, "R8 back to idle",
            {29'h0, rsp_done, req_ready, ext_valid}, 32'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_area = '0; req_addr = '0;
        req_size = '0; req_write = 1'b0; req_wdata = '0;
        cfg_big = '0; cfg_wide = '0; ext_rdata = '0; ext_ack = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && ext_valid === 1'b0 && rsp_done === 1'b0 && rsp_err === 1'b0,
            "R1 reset state", {28'h0, req_ready, ext_valid, rsp_done, rsp_err}, 32'h8);

        for (int j = 0; j < NV; j++) begin
            run_vec(VEC[j], 1'b1, 1'b0);
            run_vec(VEC[j], 1'b0, 1'b0);
        end

        // R10: big-endian 8-bit longword, area config inverted after first beat
        run_vec(VEC[8], 1'b1, 1'b1);
        run_vec(VEC[8], 1'b0, 1'b1);

        // R8: misaligned and reserved requests
        bad_req(1'b1, 2'd1, 32'h1);
        bad_req(1'b0, 2'd2, 32'h6);
        bad_req(1'b1, 2'd2, 32'h1);
        bad_req(1'b1, 2'd3, 32'h0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule